// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block applies a new divider setting to one PLL without letting the PLL's output run while its configuration changes. A caller presents a 24-bit divider word and the VCO rate that the setting produces, then pulses a request. The block gates the PLL output and writes the VCO band code into the low control word. It then writes the divider word into the high control word in the same write as the calibration and update bits. It waits first for the lock flag and then for the updating flag to drop, and opens the output again.

Each register write leaves the block as a strobe with a bit mask and data, so the register file keeps every bit that lies outside the mask. Both waits sample their status input once per microsecond tick. The tick comes from a prescaler on the system clock. Each wait gives up after a set number of samples. A timeout only raises a warning flag, and the output is enabled in every case. A build-time option makes an instance read-only. Such an instance ignores requests and only presents the divider fields of its current high control word.

Top module: `pll_reprog_seq`

## Requirements
- R1: A request taken while the block is idle starts the sequence. In the next cycle the only strobe is an enable write with data 0, and it comes before any control word changes.
- R2: One cycle after the gate write comes a low-word write with mask 0x0003_0000. Its bits 17:16 carry code 2 when the VCO rate in Hz is below TICK-independent threshold 2,400,000,000 and code 3 at or above it.
- R3: One cycle after the low write comes a high-word write with mask 0x79FF_FFFF. Its data holds the divider word in bits 23:0 (feedback 11:0, reference 17:12, first post 20:18, second post 23:21), calibrate enable at bit 24, calibrate code 2 in bits 29:27, update enable at bit 30, and zeros in bits 26:25 and 31.
- R4: Let h be the cycle of the high write and T be TICK_DIV. The lock input is sampled in cycles h+T, h+2T, and so on. Once it reads 1, the updating input is sampled every T cycles after that, and it must read 0.
- R5: A wait phase times out after POLL_LIMIT failing samples and sets the warning flag. A lock timeout skips the updating phase.
- R6: The enable write with data 1 comes in the cycle after the final successful sample or the timeout. Done is high for exactly one cycle, the cycle after the enable write.
- R7: The warning flag is valid while done is high. It holds until the next accepted request, which clears it in the gate cycle.
- R8: A request that arrives while a sequence is running has no effect. Each sequence produces exactly one gate write and one done pulse.
- R9: A read-only instance ignores requests. It produces no strobe and no done.
- R10: The divider readback output equals the current high-word divider bits in every instance.
- R11: After reset the block is idle, with all strobes, done and the warning flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Reprogramming request |
| req_div_i | input | 24 | New divider word |
| req_vco_hz_i | input | 32 | VCO rate of the new setting in Hz |
| lo_we_o | output | 1 | Low control word write strobe |
| lo_wmask_o | output | 32 | Bits of the low word written |
| lo_wdata_o | output | 32 | Low word write data |
| hi_we_o | output | 1 | High control word write strobe |
| hi_wmask_o | output | 32 | Bits of the high word written |
| hi_wdata_o | output | 32 | High word write data |
| en_we_o | output | 1 | Output enable bit write strobe |
| en_wdata_o | output | 1 | Value written to the output enable bit |
| lock_i | input | 1 | PLL lock status |
| updating_i | input | 1 | PLL updating status |
| hi_q_i | input | 24 | Divider bits of the current high control word |
| div_readback_o | output | 24 | Divider fields presented for readback |
| done_o | output | 1 | One-cycle completion pulse |
| warn_o | output | 1 | A wait phase timed out |

## Verification
The assertions assume that the register file takes each strobe in the cycle it is raised, so no write is held off or repeated. They also assume that the lock and updating inputs are synchronous to the clock. The bench drives both status inputs from negative clock edges as step functions measured from the high-word write: lock rises after a chosen delay and updating falls after another. It draws these delays at random over a range that covers early success, success on the last sample and timeouts in both phases. Requests are raised only from idle, except in one directed case that holds the request high for the whole sequence.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_GATE, S_BAND, S_DIVW, S_WLOCK, S_WUPD, S_ENABLE, S_DONE
  } seq_state_t;

  localparam int DIV_W      = 24;
  localparam int BAND_LSB   = 16;
  localparam int CALEN_BIT  = 24;
  localparam int CAL_LSB    = 27;
  localparam int UPD_BIT    = 30;
  localparam logic [2:0] CAL_CODE  = 3'd2;
  localparam logic [1:0] BAND_SLOW = 2'd2;
  localparam logic [1:0] BAND_FAST = 2'd3;

  function automatic logic [1:0] band_code(logic [63:0] rate, logic [63:0] split);
    return (rate < split) ? BAND_SLOW : BAND_FAST;
  endfunction

  function automatic logic [31:0] lo_mask();
    return 32'h3 << BAND_LSB;
  endfunction

  function automatic logic [31:0] lo_word(logic [1:0] code);
    return {30'd0, code} << BAND_LSB;
  endfunction

  function automatic logic [31:0] hi_mask();
    logic [31:0] m;
    m = {{(32-DIV_W){1'b0}}, {DIV_W{1'b1}}};
    m[CALEN_BIT] = 1'b1;
    m[CAL_LSB +: 3] = 3'b111;
    m[UPD_BIT] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] hi_word(logic [DIV_W-1:0] div);
    logic [31:0] w;
    w = {{(32-DIV_W){1'b0}}, div};
    w[CALEN_BIT] = 1'b1;
    w[CAL_LSB +: 3] = CAL_CODE;
    w[UPD_BIT] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/pll_seq_tick.sv
module pll_seq_tick #(
  parameter int TICK_DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_seq_pollcnt.sv
module pll_seq_pollcnt #(
  parameter int POLL_LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic last
);
  localparam int PW = $clog2(POLL_LIMIT + 1);
  localparam logic [PW-1:0] LAST = PW'(POLL_LIMIT - 1);

  logic [PW-1:0] cnt;

  assign last = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (step)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pll_seq_wordgen.sv
module pll_seq_wordgen
  import pll_seq_pkg::*;
(
  input  logic [DIV_W-1:0] div,
  input  logic [1:0]       band,
  output logic [31:0]      lo_mask_w,
  output logic [31:0]      lo_data_w,
  output logic [31:0]      hi_mask_w,
  output logic [31:0]      hi_data_w
);
  always_comb begin
    lo_mask_w = lo_mask();
    lo_data_w = lo_word(band);
    hi_mask_w = hi_mask();
    hi_data_w = hi_word(div);
  end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_seq_pkg::*;
#(
  parameter int              TICK_DIV   = 200,
  parameter int              POLL_LIMIT = 100000,
  parameter int              VCO_W      = 32,
  parameter logic [VCO_W-1:0] BAND_SPLIT = 32'd2400000000,
  parameter bit              READ_ONLY  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [23:0]      req_div_i,
  input  logic [VCO_W-1:0] req_vco_hz_i,
  output logic             lo_we_o,
  output logic [31:0]      lo_wmask_o,
  output logic [31:0]      lo_wdata_o,
  output logic             hi_we_o,
  output logic [31:0]      hi_wmask_o,
  output logic [31:0]      hi_wdata_o,
  output logic             en_we_o,
  output logic             en_wdata_o,
  input  logic             lock_i,
  input  logic             updating_i,
  input  logic [23:0]      hi_q_i,
  output logic [23:0]      div_readback_o,
  output logic             done_o,
  output logic             warn_o
);
  seq_state_t       state, state_nx;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       band_q;
  logic             warn_q;

  // named internal events
  logic accept_w, waiting_w, tick_w, poll_last_w;
  logic phase_adv_w, timeout_w, finish_w;

  generate
    if (READ_ONLY) begin : g_ro
      logic unused_req;
      assign unused_req = req_i;
      assign accept_w   = 1'b0;
    end else begin : g_rw
      assign accept_w = req_i && (state == S_IDLE);
    end
  endgenerate

  assign waiting_w   = (state == S_WLOCK) || (state == S_WUPD);
  assign phase_adv_w = (state == S_WLOCK) && tick_w && lock_i;
  assign finish_w    = (state == S_WUPD)  && tick_w && !updating_i;
  assign timeout_w   = tick_w && poll_last_w &&
                       (((state == S_WLOCK) && !lock_i) ||
                        ((state == S_WUPD)  &&  updating_i));

  pll_seq_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(waiting_w), .tick(tick_w)
  );

  pll_seq_pollcnt #(.POLL_LIMIT(POLL_LIMIT)) u_poll (
    .clk(clk), .rst_n(rst_n),
    .clr(!waiting_w || phase_adv_w),
    .step(tick_w),
    .last(poll_last_w)
  );

  pll_seq_wordgen u_word (
    .div(div_q), .band(band_q),
    .lo_mask_w(lo_wmask_o), .lo_data_w(lo_wdata_o),
    .hi_mask_w(hi_wmask_o), .hi_data_w(hi_wdata_o)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      S_IDLE:   if (accept_w) state_nx = S_GATE;
      S_GATE:   state_nx = S_BAND;
      S_BAND:   state_nx = S_DIVW;
      S_DIVW:   state_nx = S_WLOCK;
      S_WLOCK:  if (phase_adv_w) state_nx = S_WUPD;
                else if (timeout_w) state_nx = S_ENABLE;
      S_WUPD:   if (finish_w || timeout_w) state_nx = S_ENABLE;
      S_ENABLE: state_nx = S_DONE;
      S_DONE:   state_nx = S_IDLE;
      default:  state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      div_q  <= '0;
      band_q <= BAND_SLOW;
      warn_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept_w) begin
        div_q  <= req_div_i;
        band_q <= band_code(64'(req_vco_hz_i), 64'(BAND_SPLIT));
        warn_q <= 1'b0;
      end else if (timeout_w) begin
        warn_q <= 1'b1;
      end
    end
  end

  assign en_we_o        = (state == S_GATE) || (state == S_ENABLE);
  assign en_wdata_o     = (state == S_ENABLE);
  assign lo_we_o        = (state == S_BAND);
  assign hi_we_o        = (state == S_DIVW);
  assign done_o         = (state == S_DONE);
  assign warn_o         = warn_q;
  assign div_readback_o = hi_q_i;
endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter bit RO = 1'b0
) (
  input logic        clk,
  input logic        rst_n,
  input logic        lo_we,
  input logic [31:0] lo_wmask,
  input logic [1:0]  lo_band,
  input logic        hi_we,
  input logic [31:0] hi_wmask,
  input logic        en_we,
  input logic        en_wdata,
  input logic        done,
  input logic        warn
);
  a_r1_gate_before_band: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |-> $past(en_we && !en_wdata));

  a_r2_band_field: assert property (@(posedge clk) disable iff (!rst_n)
    lo_we |-> (lo_wmask == 32'h0003_0000) && lo_band[1]);

  a_r3_div_after_band: assert property (@(posedge clk) disable iff (!rst_n)
    hi_we |-> $past(lo_we) && (hi_wmask == 32'h79FF_FFFF));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lo_we, hi_we, en_we}));

  a_r6_done_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(en_we && en_wdata));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_warn_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn) |=> done);

  a_r9_ro_silent: assert property (@(posedge clk) disable iff (!rst_n)
    RO |-> !(lo_we || hi_we || en_we || done));
endmodule

bind pll_reprog_seq pll_seq_chk #(.RO(READ_ONLY)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .lo_we(lo_we_o), .lo_wmask(lo_wmask_o), .lo_band(lo_wdata_o[17:16]),
  .hi_we(hi_we_o), .hi_wmask(hi_wmask_o),
  .en_we(en_we_o), .en_wdata(en_wdata_o),
  .done(done_o), .warn(warn_o)
);

// File: tb/sim_pll_reprog_seq.sv
`timescale 1ns/1ps
module sim_pll_reprog_seq;
  localparam int T = 3;
  localparam int P = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req = 0, ro_req = 0;
  logic [23:0] div = 0;
  logic [31:0] vco = 0;
  logic        lock = 0, upd = 1;
  logic [23:0] hq = 0;

  logic        lo_we, hi_we, en_we, en_wd, done, warn;
  logic [31:0] lo_m, lo_d, hi_m, hi_d;
  logic [23:0] rb;
  logic        r_lo, r_hi, r_en, r_enwd, r_done, r_warn;
  logic [31:0] r_lom, r_lod, r_him, r_hid;
  logic [23:0] r_rb;

  int n_chk = 0, n_bad = 0;

  pll_reprog_seq #(.TICK_DIV(T), .POLL_LIMIT(P)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_div_i(div), .req_vco_hz_i(vco),
    .lo_we_o(lo_we), .lo_wmask_o(lo_m), .lo_wdata_o(lo_d),
    .hi_we_o(hi_we), .hi_wmask_o(hi_m), .hi_wdata_o(hi_d),
    .en_we_o(en_we), .en_wdata_o(en_wd), .lock_i(lock), .updating_i(upd),
    .hi_q_i(hq), .div_readback_o(rb), .done_o(done), .warn_o(warn));

  pll_reprog_seq #(.TICK_DIV(T), .POLL_LIMIT(P), .READ_ONLY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .req_i(ro_req), .req_div_i(div), .req_vco_hz_i(vco),
    .lo_we_o(r_lo), .lo_wmask_o(r_lom), .lo_wdata_o(r_lod),
    .hi_we_o(r_hi), .hi_wmask_o(r_him), .hi_wdata_o(r_hid),
    .en_we_o(r_en), .en_wdata_o(r_enwd), .lock_i(lock), .updating_i(upd),
    .hi_q_i(hq), .div_readback_o(r_rb), .done_o(r_done), .warn_o(r_warn));

  task automatic check(bit ok, string req_tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  function automatic logic [1:0] f_band(logic [31:0] hz);
    return (hz >= 32'd2400000000) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic [31:0] f_hi(logic [23:0] d);
    return 32'h4000_0000 + 32'h1000_0000 + 32'h0100_0000 + {8'd0, d};
  endfunction

  // offset of the enable write from the high write, and expected warning
  function automatic int f_en_off(int dl, int du, output bit w);
    int k, m;
    k = (dl + T - 1) / T;
    if (k < 1) k = 1;
    if (k > P) begin w = 1; return P * T + 1; end
    m = (du > k * T) ? (du - k * T + T - 1) / T : 1;
    if (m > P) begin w = 1; return k * T + P * T + 1; end
    w = 0;
    return k * T + m * T + 1;
  endfunction

  task automatic txn(logic [23:0] d, logic [31:0] hz, int dl, int du, bit hold);
    int gates, dones, en_c, done_c, h, exp_off;
    bit ew, warn_at_done;
    gates = 0; dones = 0; en_c = -1; done_c = -1; h = 3;
    exp_off = f_en_off(dl, du, ew);
    warn_at_done = 0;
    @(negedge clk);
    req = 1; div = d; vco = hz;
    for (int c = 1; c < 3 + 2 * P * T + 8; c++) begin
      @(negedge clk);
      if (!hold) req = 0;
      if (c == 1) begin
        check(en_we && !en_wd && !lo_we && !hi_we, "R1 gate write", {en_we, en_wd}, 2'b10);
        check(warn == 0, "R7 warn cleared on request", warn, 0);
      end
      if (c == 2) begin
        check(lo_we && lo_m == 32'h0003_0000, "R2 low strobe/mask", lo_m, 32'h0003_0000);
        check(lo_d[17:16] == f_band(hz), "R2 band code", lo_d[17:16], f_band(hz));
      end
      if (c == 3) begin
        check(hi_we && hi_m == 32'h79FF_FFFF, "R3 high strobe/mask", hi_m, 32'h79FF_FFFF);
        check(hi_d == f_hi(d), "R3 high data", hi_d, f_hi(d));
      end
      if (en_we && !en_wd) gates++;
      if (en_we && en_wd && en_c < 0) begin en_c = c; req = 0; end
      if (done) begin
        dones++;
        if (done_c < 0) begin done_c = c; warn_at_done = warn; end
      end
      lock = (c >= h) && (c - h >= dl);
      upd  = !((c >= h) && (c - h >= du));
    end
    lock = 0; upd = 1; req = 0;
    check(gates == 1, "R8 single gate write", gates, 1);
    check(en_c == h + exp_off, "R4 R5 enable cycle", en_c, h + exp_off);
    check(done_c == en_c + 1 && dones == 1, "R6 done pulse", done_c, en_c + 1);
    check(warn_at_done == ew, "R5 warning", warn_at_done, ew);
    check(warn == ew, "R7 warn held", warn, ew);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    repeat (3) @(negedge clk);
    check(!lo_we && !hi_we && !en_we && !done && !warn, "R11 reset idle",
          {lo_we, hi_we, en_we, done, warn}, 0);
    rst_n = 1;
    @(negedge clk);
    check(!lo_we && !hi_we && !en_we && !done && !warn, "R11 idle after reset",
          {lo_we, hi_we, en_we, done, warn}, 0);

    // directed corners
    txn(24'h123456, 32'd2399999999, 1, 1, 0);       // band below split, fast lock
    txn(24'hABCDEF, 32'd2400000000, 15, 15, 0);     // band at split, last lock sample
    txn(24'h000008, 32'd3200000000, 40, 1, 0);      // lock timeout
    repeat (4) @(negedge clk);
    check(warn == 1, "R7 warn persists in idle", warn, 1);
    txn(24'hFFFFFF, 32'd1600000000, 2, 60, 0);      // updating timeout
    txn(24'h0F0F0F, 32'd2500000000, 4, 8, 1);       // request held throughout

    for (int i = 0; i < 14; i++)
      txn(24'($urandom), 32'd1600000000 + ($urandom % 32'd1600000001),
          1 + int'($urandom % 20), 1 + int'($urandom % 30), ($urandom % 4) == 0);

    // read-only instance
    for (int c = 0; c < 20; c++) begin
      ro_req = 1;
      @(negedge clk);
      check(!r_lo && !r_hi && !r_en && !r_done, "R9 read-only silent",
            {r_lo, r_hi, r_en, r_done}, 0);
    end
    ro_req = 0;

    for (int i = 0; i < 4; i++) begin
      hq = 24'($urandom);
      @(negedge clk);
      check(rb == hq, "R10 readback rw", rb, hq);
      check(r_rb == hq, "R10 readback ro", r_rb, hq);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule